// File: doc/BRIEF.md
# Serial Gain-Code Load Port

This block is a three-wire control port that sets the gain of a digitally stepped amplifier. An external controller drives a serial clock, a data line and an active-low load line. The block samples all three on its own system clock through synchronizers and finds the serial-clock edges in that clock domain. While the load line is low, it shifts an 8-bit word in, most significant bit first. When the load line rises, the shifted word becomes the active gain code.

Only the six low bits of the word count. The result is clamped to the legal span of 1 to 60, where each step is 1 dB. Each commit raises a one-cycle update strobe. The block also combines a transmit-enable input and an active-low sleep input into a two-bit power state. The system clock must run at least four times as fast as the serial clock.

Top module: `gain_serial_port`

## Requirements
- R1: After reset, gain_code is 1, gain_update is 0 and power_state is 0 (sleep).
- R2: While load_n is low, each rising edge of ser_clk shifts ser_data into an 8-bit register, MSB first. A commit uses the last eight bits shifted.
- R3: A low-to-high transition of load_n copies the shifted word into gain_code. gain_update is high for exactly one system-clock cycle per commit, and gain_code changes only in a cycle where gain_update is high.
- R4: Rising edges of ser_clk while load_n is high do not alter the shift register. A later commit with no new bits reproduces the previous code.
- R5: A high-to-low transition of load_n leaves gain_code unchanged and raises no gain_update.
- R6: The two upper bits of the word are ignored. Binary 01001011 commits code 11.
- R7: Six-bit values 61, 62 and 63 commit code 60.
- R8: A six-bit value of 0 commits code 1. gain_code always lies in 1 to 60.
- R9: power_state is 0 (sleep) when sleep_n is low, whatever tx_en is. It is 1 (transmit off) when sleep_n is high and tx_en is low, and 2 (transmit on) when both are high. It never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Active-low load; rising edge commits |
| tx_en | input | 1 | Transmit enable, asynchronous |
| sleep_n | input | 1 | Active-low full power-down, asynchronous |
| gain_code | output | 6 | Active gain code, 1 to 60 |
| gain_update | output | 1 | One-cycle strobe on each commit |
| power_state | output | 2 | 0 sleep, 1 transmit off, 2 transmit on |

## Verification
The hardest case to reach from the ports is a shift register that moved while it should have been held. When load_n is high, the register's contents cannot be seen until a later commit. The stimulus commits a known word, toggles ser_clk with ones on ser_data while load_n is high, then lowers and raises load_n with no clock edges between. The resulting code shows whether the held word survived. A separate falling-edge-only test checks that the code is frozen and that no strobe appears.

// File: rtl/gain_port_pkg.sv
package gain_port_pkg;

   typedef enum logic [1:0] {
      PWR_SLEEP  = 2'd0,
      PWR_TX_OFF = 2'd1,
      PWR_TX_ON  = 2'd2
   } pwr_state_e;

   localparam int unsigned DEF_WORD_W = 8;
   localparam int unsigned DEF_CODE_W = 6;
   localparam int unsigned DEF_CODE_MIN = 1;
   localparam int unsigned DEF_CODE_MAX = 60;

endpackage

// File: rtl/gsp_sync_bank.sv
module gsp_sync_bank #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gsp_sync_bank: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/gsp_shift_commit.sv
module gsp_shift_commit #(
   parameter int unsigned WORD_W   = 8,
   parameter int unsigned CODE_W   = 6,
   parameter int unsigned CODE_MIN = 1,
   parameter int unsigned CODE_MAX = 60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              sdat_s,
   input  logic              load_n_s,
   output logic [CODE_W-1:0] gain_code,
   output logic              gain_update
);

   localparam logic [CODE_W-1:0] MIN_C = CODE_W'(CODE_MIN);
   localparam logic [CODE_W-1:0] MAX_C = CODE_W'(CODE_MAX);

   if (CODE_W > WORD_W) begin : g_bad_width
      $error("gsp_shift_commit: CODE_W exceeds WORD_W");
   end
   if (CODE_MAX >= (1 << CODE_W) || CODE_MIN > CODE_MAX || CODE_MIN == 0) begin : g_bad_range
      $error("gsp_shift_commit: code range does not fit");
   end

   logic              sclk_d, load_d;
   logic [WORD_W-1:0] shreg;
   logic [CODE_W-1:0] gain_q;
   logic              upd_q;
   logic              sclk_rise, load_rise;
   logic [CODE_W-1:0] raw_code, clamped;

   assign sclk_rise = sclk_s & ~sclk_d;
   assign load_rise = load_n_s & ~load_d;
   assign raw_code  = shreg[CODE_W-1:0];

   always_comb begin
      if (raw_code > MAX_C)      clamped = MAX_C;
      else if (raw_code < MIN_C) clamped = MIN_C;
      else                       clamped = raw_code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         load_d <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         load_d <= load_n_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     shreg <= '0;
      else if (sclk_rise && !load_n_s) shreg <= {shreg[WORD_W-2:0], sdat_s};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain_q <= MIN_C;
         upd_q  <= 1'b0;
      end else begin
         upd_q <= load_rise;
         if (load_rise) gain_q <= clamped;
      end
   end

   assign gain_code   = gain_q;
   assign gain_update = upd_q;

   // R8
   code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_q >= MIN_C) && (gain_q <= MAX_C));

   // R3
   update_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_q |=> !upd_q);

   // R3
   code_moves_with_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_q != $past(gain_q)) |-> upd_q);

   // R4
   hold_when_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_n_s |=> $stable(shreg));

endmodule

// File: rtl/gsp_power_decode.sv
module gsp_power_decode
   import gain_port_pkg::*;
(
   input  logic       tx_en_s,
   input  logic       sleep_n_s,
   output pwr_state_e state
);

   always_comb begin
      if (!sleep_n_s)    state = PWR_SLEEP;
      else if (!tx_en_s) state = PWR_TX_OFF;
      else               state = PWR_TX_ON;
   end

endmodule

// File: rtl/gain_serial_port.sv
module gain_serial_port
   import gain_port_pkg::*;
#(
   parameter int unsigned WORD_W      = DEF_WORD_W,
   parameter int unsigned CODE_W      = DEF_CODE_W,
   parameter int unsigned CODE_MIN    = DEF_CODE_MIN,
   parameter int unsigned CODE_MAX    = DEF_CODE_MAX,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              load_n,
   input  logic              tx_en,
   input  logic              sleep_n,
   output logic [CODE_W-1:0] gain_code,
   output logic              gain_update,
   output logic [1:0]        power_state
);

   localparam int unsigned N_SYNC = 5;
   // bit order: sleep_n, tx_en, load_n, ser_data, ser_clk
   localparam logic [N_SYNC-1:0] SYNC_RST = 5'b00100;

   logic [N_SYNC-1:0] raw_in, synced;
   pwr_state_e        pstate;

   assign raw_in = {sleep_n, tx_en, load_n, ser_data, ser_clk};

   gsp_sync_bank #(
      .WIDTH  (N_SYNC),
      .STAGES (SYNC_STAGES),
      .RST_VAL(SYNC_RST)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(raw_in),
      .sync_out(synced)
   );

   gsp_shift_commit #(
      .WORD_W  (WORD_W),
      .CODE_W  (CODE_W),
      .CODE_MIN(CODE_MIN),
      .CODE_MAX(CODE_MAX)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk_s     (synced[0]),
      .sdat_s     (synced[1]),
      .load_n_s   (synced[2]),
      .gain_code  (gain_code),
      .gain_update(gain_update)
   );

   gsp_power_decode u_pwr (
      .tx_en_s  (synced[3]),
      .sleep_n_s(synced[4]),
      .state    (pstate)
   );

   assign power_state = pstate;

   // R9
   sleep_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !synced[4] |-> (power_state == 2'd0));

   // R9
   no_bad_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      power_state != 2'd3);

   // R5
   fall_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(synced[2]) |=> !gain_update);

endmodule

// File: tb/gain_serial_port_tb.sv
module gain_serial_port_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_clk = 1'b0;
   logic       ser_data = 1'b0;
   logic       load_n = 1'b1;
   logic       tx_en = 1'b0;
   logic       sleep_n = 1'b0;
   logic [5:0] gain_code;
   logic       gain_update;
   logic [1:0] power_state;

   int checks = 0;
   int errors = 0;
   int pulses = 0;

   always #5 clk = ~clk;

   gain_serial_port u_dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .load_n(load_n), .tx_en(tx_en), .sleep_n(sleep_n),
      .gain_code(gain_code), .gain_update(gain_update), .power_state(power_state)
   );

   always @(negedge clk) if (rst_n && gain_update) pulses++;

   // {word, expected code}
   localparam int NV = 10;
   localparam logic [13:0] VEC [NV] = '{
      {8'h4B, 6'd11},   // R6
      {8'd30, 6'd30},   // R2
      {8'd60, 6'd60},   // R2
      {8'd61, 6'd60},   // R7
      {8'd62, 6'd60},   // R7
      {8'd63, 6'd60},   // R7
      {8'hFF, 6'd60},   // R6
      {8'h00, 6'd1},    // R8
      {8'hC0, 6'd1},    // R8
      {8'hA5, 6'd37}    // R6
   };

   task automatic waitn(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic ser_bit(input logic b);
      ser_data = b;
      ser_clk = 1'b0;
      waitn(4);
      ser_clk = 1'b1;
      waitn(4);
   endtask

   task automatic shift_word(input logic [7:0] w);
      for (int i = 7; i >= 0; i--) ser_bit(w[i]);
      ser_clk = 1'b0;
      waitn(4);
   endtask

   task automatic load_word(input logic [7:0] w);
      load_n = 1'b0;
      waitn(4);
      shift_word(w);
      load_n = 1'b1;
      waitn(8);
   endtask

   initial begin
      int p0;
      waitn(3);
      // R1
      check("R1 gain", gain_code, 1);
      check("R1 update", gain_update, 0);
      check("R1 power", power_state, 0);
      rst_n = 1'b1;
      waitn(6);
      check("R1 gain after release", gain_code, 1);

      for (int v = 0; v < NV; v++) begin
         p0 = pulses;
         load_word(VEC[v][13:6]);
         check("R2 vector code", gain_code, VEC[v][5:0]);
         check("R3 one pulse", pulses - p0, 1);
      end

      // R2: more than 8 bits, last eight count
      load_n = 1'b0;
      waitn(4);
      ser_bit(1'b1); ser_bit(1'b1); ser_bit(1'b1);
      shift_word(8'd17);
      load_n = 1'b1;
      waitn(8);
      check("R2 last eight bits", gain_code, 17);

      // R4: clocks with load_n high are ignored
      load_word(8'd30);
      shift_word(8'hFF);
      p0 = pulses;
      load_n = 1'b0;
      waitn(8);
      // R5: falling edge freezes, no strobe
      check("R5 gain frozen", gain_code, 30);
      check("R5 no pulse", pulses - p0, 0);
      load_n = 1'b1;
      waitn(8);
      check("R4 held word", gain_code, 30);
      check("R3 recommit pulse", pulses - p0, 1);

      // R9 power states
      sleep_n = 1'b0; tx_en = 1'b1; waitn(6);
      check("R9 sleep tx on", power_state, 0);
      sleep_n = 1'b1; tx_en = 1'b0; waitn(6);
      check("R9 tx off", power_state, 1);
      tx_en = 1'b1; waitn(6);
      check("R9 tx on", power_state, 2);
      sleep_n = 1'b0; waitn(6);
      check("R9 back to sleep", power_state, 0);
      check("R9 gain kept", gain_code, 30);

      // R1 reset mid-use
      rst_n = 1'b0;
      waitn(2);
      check("R1 reset clears code", gain_code, 1);
      rst_n = 1'b1;
      waitn(4);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule